// File: doc/BRIEF.md
# Ten-Bit Pulse-Width Modulator on an Eight-Bit Period Timer

This block makes a pulse-width modulated level from an eight-bit counter that restarts at zero each time it reaches a programmable period value. Two more bits taken from the prescaler in front of the counter sit below the counter. This gives a ten-bit time base, so the duty value has four times the resolution of the counter.

Software writes the period, the duty word, the prescale ratio and the interrupt postscale ratio through a small write-only register port. The duty value is the upper ten bits of a sixteen-bit word. It is copied into a shadow latch only when a period ends, so a write never disturbs the pulse in progress. A postscaler counts period ends and raises a one-cycle interrupt pulse on every Nth one.

Top module: `pwm10_timer`

## Requirements
- R1: After reset the output and the interrupt are low, the period register is 255, the prescale is 1:1, the postscale is 1:1, and the duty register and its latch are 0.
- R2: When wr_en is high, the write is captured at the clock edge. wr_addr 0 writes the period (wr_data[7:0]), 1 writes the 16-bit duty word, 2 writes the prescale select (wr_data[1:0]: 0,1,2,3 give 1:1,1:4,1:16,1:64) and 3 writes the postscale select (wr_data[3:0] = N gives 1:N+1). A prescale write restarts the prescaler.
- R3: With prescale P and period value PR, the counter advances every 4·P clocks and runs 0..PR, so one period lasts 4·P·(PR+1) clocks.
- R4: The ten-bit time base is {counter, two fraction bits}, and the fraction advances every P clocks. The output is high from the start of a period while the time base is below the latched duty D. It therefore stays high for D·P clocks of each period.
- R5: A latched duty of 0 keeps the output low for the whole period.
- R6: A latched duty of at least 4·(PR+1) keeps the output high for the whole period.
- R7: The duty word is copied into the latch only at a period end. A duty write in the middle of a period leaves that period's high time unchanged and takes effect in the next period.
- R8: Only bits 15..6 of the duty word form the duty value. Bits 5..0 have no effect on the output.
- R9: tmr_irq is a one-clock pulse, raised at the end of every (N+1)th period, where N is the postscale select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| pwm_out | output | 1 | Modulated output level |
| tmr_irq | output | 1 | Postscaled period-end pulse |

## Verification
The hardest case to reach from the ports is a duty write that lands in the middle of a period. The bench has to show that the pulse already running keeps its old width and that the next pulse takes the new one. To get there, the bench locks onto the interrupt pulse that marks a period start. It then issues the duty write a fixed number of clocks into that period, while it counts the high cycles of that period and of the following one. The same interrupt alignment lets every vector measure whole periods after any change of prescale, period or postscale.

// File: rtl/pwm10_timer.sv
module pwm10_timer #(
  parameter int TW = 8,
  parameter int RW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    wr_addr,
  input  logic [RW-1:0] wr_data,
  output logic          pwm_out,
  output logic          tmr_irq
);
  localparam int BW = TW + 2;

  logic [TW-1:0] per_r, tmr;
  logic [RW-1:0] duty_r;
  logic [BW-1:0] duty_lat;
  logic [1:0]    pre_sel;
  logic [3:0]    post_sel, post_cnt;
  logic [7:0]    pre_cnt, step_last;
  logic [1:0]    frac;

  wire wr_per  = wr_en && wr_addr == 2'd0;
  wire wr_duty = wr_en && wr_addr == 2'd1;
  wire wr_pre  = wr_en && wr_addr == 2'd2;
  wire wr_post = wr_en && wr_addr == 2'd3;

  always_comb begin
    case (pre_sel)
      2'd0:    begin step_last = 8'd3;   frac = pre_cnt[1:0]; end
      2'd1:    begin step_last = 8'd15;  frac = pre_cnt[3:2]; end
      2'd2:    begin step_last = 8'd63;  frac = pre_cnt[5:4]; end
      default: begin step_last = 8'd255; frac = pre_cnt[7:6]; end
    endcase
  end

  wire          step_end = !wr_pre && pre_cnt == step_last;
  wire          rollover = step_end && tmr >= per_r;
  wire [BW-1:0] tb       = {tmr, frac};

  assign pwm_out = tb < duty_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_r    <= '1;
      duty_r   <= '0;
      pre_sel  <= '0;
      post_sel <= '0;
      pre_cnt  <= '0;
      tmr      <= '0;
      duty_lat <= '0;
      post_cnt <= '0;
      tmr_irq  <= 1'b0;
    end else begin
      if (wr_per)  per_r    <= wr_data[TW-1:0];
      if (wr_duty) duty_r   <= wr_data;
      if (wr_pre)  pre_sel  <= wr_data[1:0];
      if (wr_post) post_sel <= wr_data[3:0];
      tmr_irq <= 1'b0;
      if (wr_pre || step_end) pre_cnt <= '0;
      else                    pre_cnt <= pre_cnt + 8'd1;
      if (step_end) begin
        if (rollover) begin
          tmr      <= '0;
          duty_lat <= duty_r[RW-1 -: BW];
          if (post_cnt == post_sel) begin
            post_cnt <= '0;
            tmr_irq  <= 1'b1;
          end else begin
            post_cnt <= post_cnt + 4'd1;
          end
        end else begin
          tmr <= tmr + 1'b1;
        end
      end
    end
  end

  assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |=> !tmr_irq) else $error("irq longer than one cycle");

  assert_latch_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rollover |=> $stable(duty_lat)) else $error("duty latch moved mid-period");

  assert_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rollover |=> (tmr == '0 && frac == 2'd0)) else $error("period did not restart at zero");

  assert_rise_at_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(pwm_out) && !$past(wr_pre)) |-> tb == '0) else $error("output rose mid-period");
endmodule

// File: tb/pwm10_timer_tb_top.sv
module pwm10_timer_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_out, tmr_irq;
  int          errors = 0;
  int          checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm10_timer dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .pwm_out(pwm_out), .tmr_irq(tmr_irq)
  );

  // {period, duty[15:6], duty[5:0] junk (R8), prescale sel, postscale sel}
  localparam logic [31:0] VECS [10] = '{
    {8'd9,   10'd20,   6'h15, 4'd0, 4'd0},
    {8'd9,   10'd0,    6'h3F, 4'd0, 4'd0},
    {8'd9,   10'd45,   6'h00, 4'd0, 4'd0},
    {8'd3,   10'd7,    6'h2A, 4'd1, 4'd0},
    {8'd2,   10'd5,    6'h01, 4'd2, 4'd0},
    {8'd1,   10'd3,    6'h20, 4'd3, 4'd0},
    {8'd4,   10'd10,   6'h0C, 4'd0, 4'd2},
    {8'd255, 10'd1000, 6'h11, 4'd0, 4'd0},
    {8'd0,   10'd2,    6'h3F, 4'd0, 4'd0},
    {8'd7,   10'd32,   6'h05, 4'd0, 4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_irq();
    @(negedge clk);
    while (!tmr_irq) @(negedge clk);
  endtask

  task automatic measure(input int wr_at, input logic [15:0] wd, output int span, output int high);
    span = 0; high = 0;
    do begin
      if (pwm_out) high++;
      if (span == wr_at) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = wd; end
      else wr_en = 1'b0;
      span++;
      @(negedge clk);
    end while (!tmr_irq);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog R1..: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int span, high;
    repeat (3) @(negedge clk);
    chk("R1 pwm in reset", int'(pwm_out), 0);
    chk("R1 irq in reset", int'(tmr_irq), 0);
    rst_n = 1'b1;
    wait_irq();
    measure(-1, '0, span, high);
    chk("R1 default period", span, 1024);
    chk("R1 default duty", high, 0);

    for (int i = 0; i < 10; i++) begin
      int pr, d, p, n, full, hi;
      pr = int'(VECS[i][31:24]); d = int'(VECS[i][23:14]);
      p = 1 << (2 * int'(VECS[i][7:4])); n = int'(VECS[i][3:0]) + 1;
      full = 4 * (pr + 1);
      hi = (d < full) ? d : full;
      wr(2'd0, {8'd0, VECS[i][31:24]});
      wr(2'd1, VECS[i][23:8]);
      wr(2'd2, {12'd0, VECS[i][7:4]});
      wr(2'd3, {12'd0, VECS[i][3:0]});
      wait_irq();
      measure(-1, '0, span, high);
      if (n > 1) chk("R9 postscaled span", span, n * full * p);
      else       chk("R2/R3 period", span, full * p);
      if (d == 0)         chk("R5/R8 high time", high, 0);
      else if (d >= full) chk("R6/R8 high time", high, n * full * p);
      else                chk("R4/R8 high time", high, n * hi * p);
    end

    // R9: pulse lasts exactly one clock
    wait_irq();
    @(negedge clk);
    chk("R9 irq width", int'(tmr_irq), 0);

    // R7: mid-period duty write
    wr(2'd0, 16'd9);
    wr(2'd1, 16'(20 << 6));
    wr(2'd2, 16'd0);
    wr(2'd3, 16'd0);
    wait_irq();
    wait_irq();
    measure(5, 16'(30 << 6), span, high);
    chk("R7 current period kept", high, 20);
    measure(-1, '0, span, high);
    chk("R7 next period updated", high, 30);

    // R8: low bits alone change nothing
    wr(2'd1, 16'((30 << 6) | 6'h3F));
    wait_irq();
    measure(-1, '0, span, high);
    chk("R8 low bits ignored", high, 30);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule